// File: doc/BRIEF.md
# Exception Pend and Status Control Registers

This unit is a small register window that lets software observe and steer the exception state held by an external prioritiser. The prioritiser reports per-vector pending flags for the system exceptions and the external lines. It also reports the number of the exception now being serviced and the number of the highest pending one, both in internal numbering. The unit packs these into one status word. Internal numbering places the external lines at 32 upward, and the unit converts them back to hardware vector numbers, where external lines start at 16.

Writes to the status word do not store anything. They produce one-cycle strobes toward the prioritiser that set the NMI (vector 2) pending flag, or set or clear the pending flags of the PendSV (vector 14) and SysTick (vector 15) exceptions. A set bit and its clear bit written together act as a set only. Three other registers sit beside the status word:

- a read-only interrupt-type word;
- the vector-table base, which keeps only 128-byte aligned addresses;
- a reset-control register, which raises a one-cycle system reset request only when the write carries the correct 16-bit key.

Top module: `excp_ctl_regs`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `reg_rdata`, `vtbase`, `sysreset_req` and all five pend strobes are 0.
- R2: The status word (word address 1) holds the active vector in bits [8:0]. It is 0 when `act_valid` is low. Otherwise it is `act_num` with 16 subtracted when `act_num` is 32 or more.
- R3: Status bit 11 is 1 when `act_valid` is low, or when `act_nested` is low. Otherwise it is 0.
- R4: Status bits [20:12] hold `pend_num`, remapped in the same way as R2, when `pend_valid` is high, and 0 when it is low.
- R5: Status bit 22 is the OR of all `ext_pend` bits. No `sys_pend` bit affects it.
- R6: Status bits 26, 28 and 31 mirror `sys_pend[15]`, `sys_pend[14]` and `sys_pend[2]`.
- R7: A write to word address 1 with bit 31 set pulses `nmi_pend_set`. With bit 28 set it pulses `pendsv_pend_set`. With bit 27 set and bit 28 clear it pulses `pendsv_pend_clr`. Each strobe is high for exactly the one cycle after the write edge.
- R8: In the same write, bit 26 pulses `systick_pend_set`. Bit 25 pulses `systick_pend_clr` only when bit 26 is clear.
- R9: Word address 0 reads (32 + NUM_EXT)/32 - 1, which is 2 with the default parameters.
- R10: A write to word address 2 stores the written value with bits [6:0] forced to 0. The result drives `vtbase` and reads back at that address. Other writes leave it unchanged.
- R11: A write to word address 3 pulses `sysreset_req` for one cycle only if bits [31:16] are 0x05FA and bit 2 is 1. A wrong key, or bit 2 clear, gives no pulse. The address reads 0xFA050000.
- R12: `reg_rdata` presents the word selected by `reg_addr` one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write enable for the register window |
| reg_addr | input | 2 | Word address: 0 type, 1 status, 2 table base, 3 reset control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| act_valid | input | 1 | An exception is being serviced |
| act_num | input | IW | Active exception, internal numbering |
| act_nested | input | 1 | The active exception preempted another one |
| pend_valid | input | 1 | Some exception is pending |
| pend_num | input | IW | Highest pending exception, internal numbering |
| sys_pend | input | 16 | Pending flags of system vectors 0..15 |
| ext_pend | input | NUM_EXT | Pending flags of external lines |
| nmi_pend_set | output | 1 | Strobe: set NMI pending |
| pendsv_pend_set | output | 1 | Strobe: set PendSV pending |
| pendsv_pend_clr | output | 1 | Strobe: clear PendSV pending |
| systick_pend_set | output | 1 | Strobe: set SysTick pending |
| systick_pend_clr | output | 1 | Strobe: clear SysTick pending |
| vtbase | output | 32 | Vector-table base address |
| sysreset_req | output | 1 | One-cycle system reset request |

## Verification
Every result is registered, so each one appears after exactly one rising edge. The strobes, `vtbase` and `sysreset_req` follow the write edge. `reg_rdata` follows the edge at which its address and the prioritiser inputs are presented. A read of the table base therefore shows a new value one edge after the write, because the write and the read need separate edges. The bench changes inputs on the falling edge and samples on the next falling edge, half a period after the edge that updated the result. It samples once more a cycle later to confirm that each strobe has dropped.

// File: rtl/excp_ctl_pkg.sv
package excp_ctl_pkg;
  localparam int WORD_W   = 32;
  localparam int FIELD_W  = 9;
  localparam int VT_ALIGN = 7;

  localparam logic [1:0] RA_TYPE   = 2'd0;
  localparam logic [1:0] RA_STATE  = 2'd1;
  localparam logic [1:0] RA_VTBASE = 2'd2;
  localparam logic [1:0] RA_RSTCTL = 2'd3;

  localparam logic [15:0] RST_KEY_WR = 16'h05FA;
  localparam logic [15:0] RST_KEY_RD = 16'hFA05;

  localparam int ST_RTB      = 11;
  localparam int ST_PEND_LSB = 12;
  localparam int ST_EXTP     = 22;
  localparam int ST_TICK_CLR = 25;
  localparam int ST_TICK     = 26;
  localparam int ST_PSV_CLR  = 27;
  localparam int ST_PSV      = 28;
  localparam int ST_NMI      = 31;

  localparam int VEC_NMI  = 2;
  localparam int VEC_PSV  = 14;
  localparam int VEC_TICK = 15;

  localparam int INT_EXT_BASE = 32;
  localparam int HW_EXT_BASE  = 16;

  typedef struct packed {
    logic nmi_set;
    logic psv_set;
    logic psv_clr;
    logic tick_set;
    logic tick_clr;
  } pend_strobe_t;
endpackage

// File: rtl/excp_state_pack.sv
module excp_state_pack
  import excp_ctl_pkg::*;
#(
  parameter int NUM_EXT = 64,
  parameter int IW      = 7
) (
  input  logic              act_valid,
  input  logic [IW-1:0]     act_num,
  input  logic              act_nested,
  input  logic              pend_valid,
  input  logic [IW-1:0]     pend_num,
  input  logic [15:0]       sys_pend,
  input  logic [NUM_EXT-1:0] ext_pend,
  output logic [WORD_W-1:0] state_word
);
  localparam int REMAP_OFS = INT_EXT_BASE - HW_EXT_BASE;

  function automatic logic [FIELD_W-1:0] to_hw(input logic [IW-1:0] n);
    logic [FIELD_W-1:0] w;
    w = FIELD_W'(n);
    if (w >= FIELD_W'(INT_EXT_BASE)) w = w - FIELD_W'(REMAP_OFS);
    return w;
  endfunction

  logic [FIELD_W-1:0] act_field;
  logic [FIELD_W-1:0] pend_field;
  logic               ret_base;
  logic               ext_any;
  logic               unused_sys;

  assign act_field  = act_valid  ? to_hw(act_num)  : '0;
  assign pend_field = pend_valid ? to_hw(pend_num) : '0;
  assign ret_base   = !act_valid || !act_nested;
  assign ext_any    = |ext_pend;
  assign unused_sys = ^{sys_pend[13:3], sys_pend[1:0]};

  always_comb begin
    state_word = '0;
    state_word[FIELD_W-1:0]                     = act_field;
    state_word[ST_RTB]                          = ret_base;
    state_word[ST_PEND_LSB +: FIELD_W]          = pend_field;
    state_word[ST_EXTP]                         = ext_any;
    state_word[ST_TICK]                         = sys_pend[VEC_TICK];
    state_word[ST_PSV]                          = sys_pend[VEC_PSV];
    state_word[ST_NMI]                          = sys_pend[VEC_NMI];
  end
endmodule

// File: rtl/excp_pend_strobe.sv
module excp_pend_strobe
  import excp_ctl_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         hit,
  input  logic         nmi_bit,
  input  logic [1:0]   psv_bits,
  input  logic [1:0]   tick_bits,
  output pend_strobe_t strobe
);
  logic [1:0] set_q;
  logic [1:0] clr_q;
  logic [1:0] set_in [2];
  logic [1:0] unused_in;

  assign set_in[0] = psv_bits;
  assign set_in[1] = tick_bits;
  assign unused_in = '0;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_pair
      always_ff @(posedge clk) begin
        if (rst) begin
          set_q[g] <= 1'b0;
          clr_q[g] <= 1'b0;
        end else begin
          set_q[g] <= hit && set_in[g][1];
          clr_q[g] <= hit && set_in[g][0] && !set_in[g][1];
        end
      end
    end
  endgenerate

  logic nmi_q;
  always_ff @(posedge clk) begin
    if (rst) nmi_q <= 1'b0;
    else     nmi_q <= hit && nmi_bit;
  end

  assign strobe.nmi_set  = nmi_q;
  assign strobe.psv_set  = set_q[0];
  assign strobe.psv_clr  = clr_q[0];
  assign strobe.tick_set = set_q[1];
  assign strobe.tick_clr = clr_q[1];
endmodule

// File: rtl/excp_cfg_regs.sv
module excp_cfg_regs
  import excp_ctl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       vt_wr,
  input  logic [WORD_W-VT_ALIGN-1:0] vt_data,
  input  logic                       rc_wr,
  input  logic [15:0]                rc_key,
  input  logic                       rc_req,
  output logic [WORD_W-1:0]          vtbase,
  output logic                       sysreset_req
);
  logic [WORD_W-VT_ALIGN-1:0] vt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vt_q         <= '0;
      sysreset_req <= 1'b0;
    end else begin
      if (vt_wr) vt_q <= vt_data;
      sysreset_req <= rc_wr && (rc_key == RST_KEY_WR) && rc_req;
    end
  end

  assign vtbase = {vt_q, {VT_ALIGN{1'b0}}};
endmodule

// File: rtl/excp_ctl_regs.sv
module excp_ctl_regs
  import excp_ctl_pkg::*;
#(
  parameter int NUM_EXT = 64,
  parameter int IW      = $clog2(INT_EXT_BASE + NUM_EXT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               act_valid,
  input  logic [IW-1:0]      act_num,
  input  logic               act_nested,
  input  logic               pend_valid,
  input  logic [IW-1:0]      pend_num,
  input  logic [15:0]        sys_pend,
  input  logic [NUM_EXT-1:0] ext_pend,
  output logic               nmi_pend_set,
  output logic               pendsv_pend_set,
  output logic               pendsv_pend_clr,
  output logic               systick_pend_set,
  output logic               systick_pend_clr,
  output logic [31:0]        vtbase,
  output logic               sysreset_req
);
  localparam int NUM_LINES = INT_EXT_BASE + NUM_EXT;
  localparam logic [WORD_W-1:0] TYPE_VAL = WORD_W'(NUM_LINES / 32 - 1);

  logic [WORD_W-1:0] state_word;
  pend_strobe_t      strobe;
  logic              unused_wdata;

  assign unused_wdata = ^{reg_wdata[6:3], reg_wdata[1:0]};

  excp_state_pack #(.NUM_EXT(NUM_EXT), .IW(IW)) u_pack (
    .act_valid  (act_valid),
    .act_num    (act_num),
    .act_nested (act_nested),
    .pend_valid (pend_valid),
    .pend_num   (pend_num),
    .sys_pend   (sys_pend),
    .ext_pend   (ext_pend),
    .state_word (state_word)
  );

  excp_pend_strobe u_strobe (
    .clk       (clk),
    .rst       (rst),
    .hit       (reg_wr && reg_addr == RA_STATE),
    .nmi_bit   (reg_wdata[ST_NMI]),
    .psv_bits  ({reg_wdata[ST_PSV], reg_wdata[ST_PSV_CLR]}),
    .tick_bits ({reg_wdata[ST_TICK], reg_wdata[ST_TICK_CLR]}),
    .strobe    (strobe)
  );

  excp_cfg_regs u_cfg (
    .clk          (clk),
    .rst          (rst),
    .vt_wr        (reg_wr && reg_addr == RA_VTBASE),
    .vt_data      (reg_wdata[WORD_W-1:VT_ALIGN]),
    .rc_wr        (reg_wr && reg_addr == RA_RSTCTL),
    .rc_key       (reg_wdata[31:16]),
    .rc_req       (reg_wdata[2]),
    .vtbase       (vtbase),
    .sysreset_req (sysreset_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_TYPE:   reg_rdata <= TYPE_VAL;
        RA_STATE:  reg_rdata <= state_word;
        RA_VTBASE: reg_rdata <= vtbase;
        default:   reg_rdata <= {RST_KEY_RD, 16'h0000};
      endcase
    end
  end

  assign nmi_pend_set     = strobe.nmi_set;
  assign pendsv_pend_set  = strobe.psv_set;
  assign pendsv_pend_clr  = strobe.psv_clr;
  assign systick_pend_set = strobe.tick_set;
  assign systick_pend_clr = strobe.tick_clr;
endmodule

// File: rtl/excp_ctl_regs_chk.sv
module excp_ctl_regs_chk
  import excp_ctl_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        nmi_pend_set,
  input logic        pendsv_pend_set,
  input logic        pendsv_pend_clr,
  input logic        systick_pend_set,
  input logic        systick_pend_clr,
  input logic [31:0] vtbase,
  input logic        sysreset_req
);
  p_vt_align_r10: assert property (@(posedge clk) disable iff (rst)
    vtbase[6:0] == 7'd0);

  p_vt_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_wr && reg_addr == RA_VTBASE) |-> $stable(vtbase));

  p_nmi_src_r7: assert property (@(posedge clk) disable iff (rst)
    nmi_pend_set |-> $past(reg_wr && reg_addr == RA_STATE && reg_wdata[31]));

  p_psv_excl_r7: assert property (@(posedge clk) disable iff (rst)
    pendsv_pend_set |-> !pendsv_pend_clr);

  p_tick_excl_r8: assert property (@(posedge clk) disable iff (rst)
    systick_pend_set |-> !systick_pend_clr);

  p_rst_key_r11: assert property (@(posedge clk) disable iff (rst)
    sysreset_req |-> $past(reg_wr && reg_addr == RA_RSTCTL &&
                           reg_wdata[31:16] == 16'h05FA && reg_wdata[2]));

  p_rst_read_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr == RA_RSTCTL) && !$past(rst)) |-> reg_rdata == 32'hFA050000);
endmodule

bind excp_ctl_regs excp_ctl_regs_chk u_chk (.*);

// File: tb/excp_ctl_regs_test.sv
`timescale 1ns/1ps
module excp_ctl_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        act_valid = 1'b0;
  logic [6:0]  act_num = '0;
  logic        act_nested = 1'b0;
  logic        pend_valid = 1'b0;
  logic [6:0]  pend_num = '0;
  logic [15:0] sys_pend = '0;
  logic [63:0] ext_pend = '0;
  logic        nmi_pend_set, pendsv_pend_set, pendsv_pend_clr;
  logic        systick_pend_set, systick_pend_clr, sysreset_req;
  logic [31:0] vtbase;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  excp_ctl_regs uut (.*);

  typedef struct packed {
    logic        av;
    logic [6:0]  an;
    logic        nest;
    logic        pv;
    logic [6:0]  pn;
    logic [15:0] sp;
    logic [63:0] ep;
    logic [31:0] exp_word;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'd0,  1'b0, 1'b0, 7'd0,  16'h0000, 64'h0, 32'h00000800},
    '{1'b1, 7'd3,  1'b1, 1'b0, 7'd60, 16'h0000, 64'h0, 32'h00000003},
    '{1'b1, 7'd40, 1'b0, 1'b1, 7'd50, 16'h0000, 64'h0000_0000_0004_0000, 32'h00422818},
    '{1'b1, 7'd15, 1'b1, 1'b1, 7'd14, 16'hC004, 64'h0, 32'h9400E00F},
    '{1'b1, 7'd95, 1'b1, 1'b1, 7'd32, 16'h3FFB, 64'h0, 32'h0001004F},
    '{1'b0, 7'd20, 1'b1, 1'b1, 7'd95, 16'h8000, 64'h8000_0000_0000_0000, 32'h0444F800}
  };

  function automatic logic [31:0] strobes();
    return {26'd0, nmi_pend_set, pendsv_pend_set, pendsv_pend_clr,
            systick_pend_set, systick_pend_clr, sysreset_req};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
  endtask

  task automatic wr_strobe(input string req, input logic [31:0] d, input logic [31:0] expv);
    wr(2'd1, d);
    chk(req, strobes(), expv);
    @(negedge clk);
    chk({req, " single cycle"}, strobes(), 32'd0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 rdata in reset", reg_rdata, 32'd0);
    chk("R1 strobes in reset", strobes(), 32'd0);
    chk("R1 vtbase in reset", vtbase, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 strobes after reset", strobes(), 32'd0);
    chk("R1 vtbase after reset", vtbase, 32'd0);

    // R2..R6, R12: table of status word vectors
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      act_valid = VECS[i].av; act_num = VECS[i].an; act_nested = VECS[i].nest;
      pend_valid = VECS[i].pv; pend_num = VECS[i].pn;
      sys_pend = VECS[i].sp; ext_pend = VECS[i].ep;
      reg_addr = 2'd1;
      @(negedge clk);
      chk($sformatf("R2 R3 R4 R5 R6 R12 status vector %0d", i), reg_rdata, VECS[i].exp_word);
    end

    // R9
    rd(2'd0);
    chk("R9 type word", reg_rdata, 32'd2);

    // R7, R8: strobe order {nmi,psv_set,psv_clr,tick_set,tick_clr,reset}
    wr_strobe("R7 nmi set", 32'h8000_0000, 32'b100000);
    wr_strobe("R7 pendsv set wins", 32'h1800_0000, 32'b010000);
    wr_strobe("R7 pendsv clear", 32'h0800_0000, 32'b001000);
    wr_strobe("R8 systick set wins", 32'h0600_0000, 32'b000100);
    wr_strobe("R8 systick clear", 32'h0200_0000, 32'b000010);
    wr_strobe("R7 R8 other bits no strobe", 32'h61FF_FFFF, 32'b000000);

    // R10
    wr(2'd2, 32'h1234_5FFF);
    chk("R10 vtbase port", vtbase, 32'h1234_5F80);
    rd(2'd2);
    chk("R10 vtbase read", reg_rdata, 32'h1234_5F80);
    wr(2'd1, 32'h0000_0000);
    wr(2'd3, 32'hDEAD_BEEF);
    chk("R10 vtbase held", vtbase, 32'h1234_5F80);

    // R11
    wr(2'd3, 32'h05FA_0004);
    chk("R11 keyed reset pulse", strobes(), 32'b000001);
    @(negedge clk);
    chk("R11 reset pulse single", strobes(), 32'd0);
    wr(2'd3, 32'h05FB_0004);
    chk("R11 wrong key", strobes(), 32'd0);
    @(negedge clk);
    chk("R11 wrong key later", strobes(), 32'd0);
    wr(2'd3, 32'h05FA_0002);
    chk("R11 key without request bit", strobes(), 32'd0);
    rd(2'd3);
    chk("R11 readback", reg_rdata, 32'hFA05_0000);

    finish_run();
  end
endmodule